// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. The count is visible as a low and a high 32-bit word, and a 64-bit period sets the timeout. A plain 32-bit register port gives word-aligned access to:

- an identification word;
- the two count words;
- the two period words;
- a timer control word holding the run bit;
- a global control word holding the mode and half-release bits;
- the watchdog control word.

Reads are combinational. Writes take effect at the clock edge on which `bus_wr` is high.

Software prepares the timer in this order:

1. Release both counter halves and select watchdog mode.
2. Clear the count.
3. Load the period.
4. Set the run bit.

It then arms the watchdog with a two-step key sequence, written in bits 31:16 of the watchdog control word. The same sequence restarts the count while the watchdog is active. Any other key written while armed expires the watchdog at once.

On expiry the block drives a single-cycle reset pulse and sets a sticky timeout flag. It then stays expired until the system reset.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset every register reads zero except the identification word at offset 0x00, which reads the ID_VALUE parameter. Reads of offsets that match no register, including misaligned ones, return zero.
- R2: The 64-bit count increments by one per clock while bit 7 of the timer control word (offset 0x20) is 1 and both half-release bits are 1. A carry out of the low word (offset 0x10) advances the high word (offset 0x14). Both words are writable and readable while the watchdog is not armed.
- R3: In the global control word (offset 0x24), bit 0 releases the low count word and bit 1 releases the high count word. While a release bit is 0, its word is held at zero and writes to it have no effect.
- R4: Arming takes two writes to the watchdog control word (offset 0x28). Both writes need bit 3 of the global control word set. The first carries key 0xA5C6 in bits 31:16, the second carries key 0xDA7E, and each has bit 14 set. The sequence makes the watchdog active, clears the count to zero, and makes bit 14 read 1.
- R5: While active, when the count equals the period (0x18 low, 0x1C high), `wd_rst_pulse` is high for exactly one cycle. That cycle begins P+1 clock edges after the edge of the arming write, where P is the period. The timeout flag is set on the same edge.
- R6: While active, key 0xA5C6 followed by key 0xDA7E restarts the count from zero, so the next timeout comes P+1 edges after the second write.
- R7: While active, writing a key other than 0xA5C6 (including 0xDA7E without a preceding 0xA5C6) raises `wd_rst_pulse` on the edge of that write.
- R8: After a first key of 0xA5C6, any further write other than 0xA5C6 or 0xDA7E ends the sequence. When active, that write expires the watchdog. A repeated 0xA5C6 keeps the sequence at its first step.
- R9: While not armed, wrong keys have no effect. A key sequence without watchdog mode, or with bit 14 clear, does not arm the watchdog.
- R10: Once armed, the enable bit cannot be cleared. Writes to the count, period, timer control and global control words are ignored.
- R11: The timeout flag reads at bit 15 of the watchdog control word and on `wd_flag`. Writing 1 to bit 15 clears it.
- R12: After expiry the watchdog stays expired until reset: keys are ignored and no further pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_rst_pulse | output | 1 | One-cycle watchdog reset pulse |
| wd_flag | output | 1 | Sticky timeout flag |

## Verification
The timeout path is exercised in three ways:

- A zero period separates a match on the very first count value from an off-by-one count.
- Random periods, with random numbers of services at random delays, show whether each service truly restarts the count from zero, since the expected pulse edge moves with every service.
- Lock-protected writes to the period and the count inside those runs would shift the pulse if they leaked through.

Directed key patterns reveal whether the state machine tells arming apart from servicing and from invalid keys. These patterns are a repeated first key, a lone second key, a stray key after the first step, a sequence without mode or enable, and keys written after expiry.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;

   typedef enum logic [2:0] {
      WS_IDLE  = 3'd0,
      WS_STEP1 = 3'd1,
      WS_LIVE  = 3'd2,
      WS_SVC   = 3'd3,
      WS_DONE  = 3'd4
   } wdk_state_e;

   // register byte offsets; the register port decodes these
   localparam logic [5:0] OFS_ID     = 6'h00;
   localparam logic [5:0] OFS_CNT_LO = 6'h10;
   localparam logic [5:0] OFS_CNT_HI = 6'h14;
   localparam logic [5:0] OFS_PRD_LO = 6'h18;
   localparam logic [5:0] OFS_PRD_HI = 6'h1C;
   localparam logic [5:0] OFS_TCR    = 6'h20;
   localparam logic [5:0] OFS_GCR    = 6'h24;
   localparam logic [5:0] OFS_WCR    = 6'h28;

   localparam int TCR_RUN_BIT  = 7;
   localparam int GCR_MODE_BIT = 3;
   localparam int GCR_HI_BIT   = 1;
   localparam int GCR_LO_BIT   = 0;
   localparam int WCR_FLAG_BIT = 15;
   localparam int WCR_EN_BIT   = 14;
   localparam int WCR_KEY_LSB  = 16;

endpackage

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter #(
   parameter int HALF_W = 32,
   parameter int N_HALF = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run,
   input  logic [N_HALF-1:0]        rel,
   input  logic [N_HALF-1:0]        wr_en,
   input  logic                     clr,
   input  logic [HALF_W-1:0]        wdata,
   output logic [HALF_W*N_HALF-1:0] cnt
);

   if (HALF_W < 1) begin : g_bad_width
      $error("wdk_counter: HALF_W must be positive");
   end
   if (N_HALF < 1) begin : g_bad_halves
      $error("wdk_counter: N_HALF must be positive");
   end

   logic [N_HALF-1:0] carry;
   assign carry[0] = run;

   for (genvar i = 0; i < N_HALF; i++) begin : g_half
      logic [HALF_W-1:0] half_q;

      if (i < N_HALF - 1) begin : g_chain
         assign carry[i+1] = carry[i] & (&half_q);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                   half_q <= '0;
         else if (!rel[i] || clr)      half_q <= '0;
         else if (wr_en[i])            half_q <= wdata;
         else if (carry[i])            half_q <= half_q + 1'b1;
      end

      assign cnt[i*HALF_W +: HALF_W] = half_q;

      // R3: an unreleased word reads zero on the next cycle
      a_r3_half_held: assert property (@(posedge clk) disable iff (!rst_n)
         !rel[i] |=> (cnt[i*HALF_W +: HALF_W] == '0));
   end

endmodule

// File: rtl/wdk_keyfsm.sv
`timescale 1ns/1ps
module wdk_keyfsm
   import wdk_pkg::*;
#(
   parameter int          CNT_W       = 64,
   parameter logic [15:0] KEY_ARM     = 16'hA5C6,
   parameter logic [15:0] KEY_CONFIRM = 16'hDA7E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [15:0]      key,
   input  logic             en_req,
   input  logic             flag_wr1,
   input  logic             wd_mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] prd,
   output logic             clr_cnt,
   output logic             armed,
   output logic             wd_pulse,
   output logic             wd_flag
);

   if (KEY_ARM == KEY_CONFIRM) begin : g_bad_keys
      $error("wdk_keyfsm: the two keys must differ");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdk_keyfsm: CNT_W too small");
   end

   wdk_state_e state_q, state_d;
   logic       fire;
   logic       is_arm, is_cfm, hit, live, may_arm;

   assign is_arm  = (key == KEY_ARM);
   assign is_cfm  = (key == KEY_CONFIRM);
   assign hit     = (cnt == prd);
   assign live    = (state_q == WS_LIVE) || (state_q == WS_SVC);
   assign may_arm = en_req && wd_mode;

   always_comb begin
      state_d = state_q;
      fire    = 1'b0;
      clr_cnt = 1'b0;
      unique case (state_q)
         WS_IDLE: begin
            if (key_wr && is_arm && may_arm) state_d = WS_STEP1;
         end
         WS_STEP1: begin
            if (key_wr) begin
               if (is_arm)                    state_d = WS_STEP1;
               else if (is_cfm && may_arm) begin
                  state_d = WS_LIVE;
                  clr_cnt = 1'b1;
               end
               else                           state_d = WS_IDLE;
            end
         end
         WS_LIVE: begin
            if (hit)                          fire = 1'b1;
            else if (key_wr) begin
               if (is_arm)                    state_d = WS_SVC;
               else                           fire = 1'b1;
            end
         end
         WS_SVC: begin
            if (hit)                          fire = 1'b1;
            else if (key_wr) begin
               if (is_arm)                    state_d = WS_SVC;
               else if (is_cfm) begin
                  state_d = WS_LIVE;
                  clr_cnt = 1'b1;
               end
               else                           fire = 1'b1;
            end
         end
         WS_DONE:  state_d = WS_DONE;
         default:  state_d = WS_IDLE;
      endcase
      if (fire) state_d = WS_DONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WS_IDLE;
         wd_pulse <= 1'b0;
         wd_flag  <= 1'b0;
      end else begin
         state_q  <= state_d;
         wd_pulse <= fire;
         if (fire)                     wd_flag <= 1'b1;
         else if (key_wr && flag_wr1)  wd_flag <= 1'b0;
      end
   end

   assign armed = live || (state_q == WS_DONE);

   // R5: the reset pulse lasts one cycle
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wd_pulse |=> !wd_pulse);
   // R5: the flag is set together with the pulse
   a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wd_pulse |-> wd_flag);
   // R10: once armed, never disarmed short of reset
   a_r10_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);
   // R7: a foreign key while live expires the watchdog
   a_r7_bad_key_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (live && key_wr && key != KEY_ARM && key != KEY_CONFIRM) |=> (wd_pulse && wd_flag));
   // R6: a completed service leaves the count at zero
   a_r6_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WS_SVC && key_wr && key == KEY_CONFIRM && cnt != prd) |=> (cnt == '0));
   // R12: no second pulse after expiry
   a_r12_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WS_DONE) |=> !wd_pulse);

endmodule

// File: rtl/wdk_regs.sv
`timescale 1ns/1ps
module wdk_regs
   import wdk_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] ID_VALUE = 32'h5744_0A01,
   localparam int         CNT_W    = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              lock,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              flag,
   input  logic              armed,
   output logic [CNT_W-1:0]  prd,
   output logic              run,
   output logic [1:0]        rel,
   output logic              wd_mode,
   output logic [1:0]        cnt_wr,
   output logic              wcr_wr,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W != 32) begin : g_bad_data
      $error("wdk_regs: DATA_W must be 32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("wdk_regs: ADDR_W must cover offset 0x28");
   end

   logic s_id, s_clo, s_chi, s_plo, s_phi, s_tcr, s_gcr, s_wcr, open;

   assign s_id  = (addr == ADDR_W'(OFS_ID));
   assign s_clo = (addr == ADDR_W'(OFS_CNT_LO));
   assign s_chi = (addr == ADDR_W'(OFS_CNT_HI));
   assign s_plo = (addr == ADDR_W'(OFS_PRD_LO));
   assign s_phi = (addr == ADDR_W'(OFS_PRD_HI));
   assign s_tcr = (addr == ADDR_W'(OFS_TCR));
   assign s_gcr = (addr == ADDR_W'(OFS_GCR));
   assign s_wcr = (addr == ADDR_W'(OFS_WCR));

   assign open   = wr && !lock;
   assign cnt_wr = {open && s_chi, open && s_clo};
   assign wcr_wr = wr && s_wcr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd     <= '0;
         run     <= 1'b0;
         rel     <= 2'b00;
         wd_mode <= 1'b0;
      end else if (open) begin
         if (s_plo) prd[DATA_W-1:0]     <= wdata;
         if (s_phi) prd[CNT_W-1:DATA_W] <= wdata;
         if (s_tcr) run                 <= wdata[TCR_RUN_BIT];
         if (s_gcr) begin
            wd_mode <= wdata[GCR_MODE_BIT];
            rel     <= {wdata[GCR_HI_BIT], wdata[GCR_LO_BIT]};
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (s_id)       rdata = ID_VALUE;
      else if (s_clo) rdata = cnt[DATA_W-1:0];
      else if (s_chi) rdata = cnt[CNT_W-1:DATA_W];
      else if (s_plo) rdata = prd[DATA_W-1:0];
      else if (s_phi) rdata = prd[CNT_W-1:DATA_W];
      else if (s_tcr) rdata[TCR_RUN_BIT] = run;
      else if (s_gcr) begin
         rdata[GCR_MODE_BIT] = wd_mode;
         rdata[GCR_HI_BIT]   = rel[1];
         rdata[GCR_LO_BIT]   = rel[0];
      end
      else if (s_wcr) begin
         rdata[WCR_FLAG_BIT] = flag;
         rdata[WCR_EN_BIT]   = armed;
      end
   end

   // R10: control words cannot change while locked
   a_r10_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(run) && $stable(rel) && $stable(wd_mode) && $stable(prd)));

endmodule

// File: rtl/wdk_watchdog.sv
`timescale 1ns/1ps
module wdk_watchdog
   import wdk_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter logic [31:0] ID_VALUE    = 32'h5744_0A01,
   parameter logic [15:0] KEY_ARM     = 16'hA5C6,
   parameter logic [15:0] KEY_CONFIRM = 16'hDA7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wd_rst_pulse,
   output logic              wd_flag
);

   localparam int DATA_W = 32;
   localparam int CNT_W  = 2 * DATA_W;

   logic [CNT_W-1:0] cnt, prd;
   logic             run, wd_mode, armed, clr_cnt, wcr_wr;
   logic [1:0]       rel, cnt_wr;

   wdk_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ID_VALUE (ID_VALUE)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .lock    (armed),
      .cnt     (cnt),
      .flag    (wd_flag),
      .armed   (armed),
      .prd     (prd),
      .run     (run),
      .rel     (rel),
      .wd_mode (wd_mode),
      .cnt_wr  (cnt_wr),
      .wcr_wr  (wcr_wr),
      .rdata   (bus_rdata)
   );

   wdk_counter #(
      .HALF_W (DATA_W),
      .N_HALF (2)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run && (&rel)),
      .rel   (rel),
      .wr_en (cnt_wr),
      .clr   (clr_cnt),
      .wdata (bus_wdata),
      .cnt   (cnt)
   );

   wdk_keyfsm #(
      .CNT_W       (CNT_W),
      .KEY_ARM     (KEY_ARM),
      .KEY_CONFIRM (KEY_CONFIRM)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (wcr_wr),
      .key      (bus_wdata[DATA_W-1:WCR_KEY_LSB]),
      .en_req   (bus_wdata[WCR_EN_BIT]),
      .flag_wr1 (bus_wdata[WCR_FLAG_BIT]),
      .wd_mode  (wd_mode),
      .cnt      (cnt),
      .prd      (prd),
      .clr_cnt  (clr_cnt),
      .armed    (armed),
      .wd_pulse (wd_rst_pulse),
      .wd_flag  (wd_flag)
   );

endmodule

// File: tb/tb_wdk_watchdog.sv
`timescale 1ns/1ps
module tb_wdk_watchdog;

   localparam logic [7:0] A_ID = 8'h00, A_CLO = 8'h10, A_CHI = 8'h14, A_PLO = 8'h18,
                          A_PHI = 8'h1C, A_TCR = 8'h20, A_GCR = 8'h24, A_WCR = 8'h28;
   localparam logic [31:0] ID_EXP = 32'h5744_0A01;
   localparam logic [31:0] K0 = 32'hA5C6_4000, K1 = 32'hDA7E_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wd_rst_pulse, wd_flag;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   wdk_watchdog dut (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .wd_rst_pulse (wd_rst_pulse), .wd_flag (wd_flag)
   );

   function automatic int exp_delay(input longint p);
      return int'(p) + 1;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic setup(input logic [63:0] p, input logic [31:0] gcr);
      wr(A_GCR, gcr);
      wr(A_CLO, 32'h0);
      wr(A_CHI, 32'h0);
      wr(A_PLO, p[31:0]);
      wr(A_PHI, p[63:32]);
      wr(A_TCR, 32'h80);
   endtask

   task automatic idle(input int k, inout logic seen);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (wd_rst_pulse) seen = 1'b1;
      end
   endtask

   task automatic wait_pulse(input int limit, output int n);
      n = 0;
      while (!wd_rst_pulse && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      logic        seen;
      int          n, seed;
      seed = $urandom(1234);
      @(negedge clk);
      do_reset();

      // R1: reset values, identification, undefined offsets
      rd(A_ID, v);  check("R1 id", v, ID_EXP);
      rd(A_TCR, v); check("R1 tcr reset", v, 0);
      rd(A_WCR, v); check("R1 wcr reset", v, 0);
      rd(A_CLO, v); check("R1 count reset", v, 0);
      rd(8'h2C, v); check("R1 undefined 0x2C", v, 0);
      rd(8'h11, v); check("R1 misaligned 0x11", v, 0);
      check("R1 pulse/flag reset", {wd_rst_pulse, wd_flag}, 0);

      // R3: held words ignore writes
      wr(A_CLO, 32'h1234);
      rd(A_CLO, v); check("R3 held low word", v, 0);
      wr(A_GCR, 32'h1);
      wr(A_CHI, 32'h77);
      rd(A_CHI, v); check("R3 held high word", v, 0);

      // R2: counting with carry between words
      wr(A_GCR, 32'h3);
      wr(A_CLO, 32'hFFFF_FFFE);
      wr(A_CHI, 32'h5);
      rd(A_CLO, v); rd(A_CHI, v2); check("R2 preset", {v2, v}, 64'h5_FFFF_FFFE);
      wr(A_TCR, 32'h80);
      repeat (3) @(negedge clk);
      rd(A_CLO, v); rd(A_CHI, v2); check("R2 carry", {v2, v}, 64'h6_0000_0001);
      wr(A_TCR, 32'h0);
      rd(A_CLO, v);
      repeat (3) @(negedge clk);
      rd(A_CLO, v2); check("R2 halted", v2, v);

      // R9: no mode, no enable, wrong keys while idle
      do_reset();
      setup(64'd10, 32'h3);
      wr(A_WCR, K0); wr(A_WCR, K1);
      rd(A_WCR, v); check("R9 no mode", v, 0);
      wr(A_GCR, 32'hB);
      wr(A_WCR, 32'hA5C6_0000); wr(A_WCR, 32'hDA7E_0000);
      rd(A_WCR, v); check("R9 no enable", v, 0);
      seen = 1'b0;
      wr(A_WCR, 32'h5555_4000);
      idle(30, seen);
      check("R9 idle wrong key", {seen, wd_flag}, 0);

      // R4/R5 zero period, R11 flag, R12 expiry, R10 lock
      do_reset();
      setup(64'd0, 32'hB);
      wr(A_WCR, K0); wr(A_WCR, K1);
      rd(A_WCR, v); check("R4 armed bit", v, 32'h4000);
      wait_pulse(50, n);
      check("R5 zero period delay", n, exp_delay(0));
      check("R5 flag set", wd_flag, 1);
      @(negedge clk);
      check("R5 single cycle", wd_rst_pulse, 0);
      seen = 1'b0;
      wr(A_WCR, K0); wr(A_WCR, K1); wr(A_WCR, 32'h5555_4000);
      idle(30, seen);
      check("R12 no second pulse", seen, 0);
      rd(A_WCR, v); check("R11 flag readback", v, 32'hC000);
      wr(A_WCR, 32'h0000_8000);
      rd(A_WCR, v); check("R11 flag cleared", {wd_flag, v}, {1'b0, 32'h4000});
      wr(A_TCR, 32'h0);
      rd(A_TCR, v); check("R10 tcr locked", v, 32'h80);

      // R7: foreign key while live; R7 lone second key
      do_reset();
      setup(64'd1000, 32'hB);
      wr(A_WCR, K0); wr(A_WCR, K1);
      repeat (5) @(negedge clk);
      wr(A_WCR, 32'h5555_4000);
      check("R7 invalid key pulse", {wd_rst_pulse, wd_flag}, 2'b11);
      do_reset();
      setup(64'd1000, 32'hB);
      wr(A_WCR, K0); wr(A_WCR, K1);
      wr(A_WCR, K1);
      check("R7 lone confirm key", wd_rst_pulse, 1);

      // R8: repeated first key arms; stray key after first step expires
      do_reset();
      setup(64'd1000, 32'hB);
      wr(A_WCR, K0); wr(A_WCR, K0); wr(A_WCR, K1);
      rd(A_WCR, v); check("R8 repeated first key arms", v, 32'h4000);
      wr(A_WCR, K0); wr(A_WCR, K0);
      check("R8 repeated first key live", wd_rst_pulse, 0);
      wr(A_WCR, 32'h0000_4000);
      check("R8 stray key expires", wd_rst_pulse, 1);

      // R6/R5/R10 random periods and services
      for (int it = 0; it < 8; it++) begin
         logic [63:0] p;
         int nserv;
         p = 64'(20 + ($urandom % 60));
         nserv = int'($urandom % 4);
         do_reset();
         setup(p, 32'hB);
         wr(A_WCR, K0); wr(A_WCR, K1);
         seen = 1'b0;
         for (int s = 0; s < nserv; s++) begin
            idle(int'($urandom % (p - 6)), seen);
            wr(A_WCR, K0);
            if ($urandom % 2 == 1) wr(A_WCR, K0);
            wr(A_WCR, K1);
            if (wd_rst_pulse) seen = 1'b1;
         end
         wr(A_PLO, 32'h0);
         wr(A_CLO, 32'h0);
         wr(A_WCR, K0); wr(A_WCR, K1);
         check("R6 no early pulse", seen, 0);
         wait_pulse(500, n);
         check("R6 R5 R10 timeout after service", n, exp_delay(p));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule